// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the scan timing of a progressive (non-interlaced) LCD panel. Two free-running counters step through the pixels of each line and the lines of each frame. The block decodes horizontal and vertical sync, a display-enable window and a left-zone flag from those counters, and it raises two single-clock interrupt pulses: one when the visible part of a frame ends and one when vertical sync starts.

Every period comes from a configuration input that holds its length minus one. Each axis has a total, a sync position, a sync width and a display length. The horizontal axis also has a boundary that marks off a left zone, which is used to split layers. The block copies the configuration inputs into shadow registers, and they take effect only when a new frame starts.

The block checks that the settings are in a legal order. An illegal setting is flagged, but the counters keep running. A pixel word supplied in step with the counters comes out 13 clocks later, together with the display-enable and zone flags.

Top module: `raster_timing_gen`

## Requirements
- R1: `h_count` counts 0, 1, … up to the active horizontal total T and then returns to 0, so a line lasts T+1 clocks.
- R2: `v_count` advances by one when `h_count` wraps from T to 0, and returns to 0 after the active vertical total V, so a frame lasts V+1 lines.
- R3: Horizontal sync is active while `h_count` is between S+1 and S+W+1 inclusive, where S is the sync position and W the sync width. Active means low when the horizontal invert bit is 0 and high when it is 1.
- R4: Vertical sync is active on lines VS+1 through VS+VW+1, and it changes only when `h_count` is 0. Active means low when the vertical invert bit is 0 and high when it is 1.
- R5: `frame_irq` is a one-clock pulse in the cycle where `h_count` is 0 and `v_count` equals the vertical display setting plus one.
- R6: `vsync_irq` is a one-clock pulse in the cycle where `h_count` is 0 and `v_count` equals the vertical sync position plus one. This is the same cycle in which vertical sync becomes active.
- R7: The internal display window holds while `h_count` is at most the horizontal display setting and `v_count` is at most the vertical display setting. `de_out` equals that window as it stood 13 clocks earlier.
- R8: `pix_out` equals the `pix_in` value that was present 13 clocks earlier while `de_out` is 1, and it is all zeros while `de_out` is 0.
- R9: `left_zone` equals, 13 clocks later, the condition "display window active and `h_count` ≤ horizontal boundary".
- R10: `param_error` is 1 whenever the active settings break either of these chains: boundary ≤ display < sync position < sync position + sync width + 1 < total (horizontal), and display < sync position < sync position + sync width + 1 < total (vertical).
- R11: Changes on the configuration inputs, including the invert bits, have no effect until the clock edge that ends the current frame. Counting continues under illegal settings.
- R12: During reset, both counters are 0, both syncs are high, and `de_out`, `left_zone`, `pix_out`, both interrupts and `param_error` are 0. The first clock after reset loads the settings, and the next cycle shows pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_total | input | HW | Line length minus one |
| cfg_h_sync_pos | input | HW | Horizontal sync position minus one |
| cfg_h_sync_wid | input | HW | Horizontal sync width minus one |
| cfg_h_disp | input | HW | Visible pixels per line minus one |
| cfg_h_bound | input | HW | Last pixel of the left zone |
| cfg_v_total | input | VW | Lines per frame minus one |
| cfg_v_sync_pos | input | VW | Vertical sync position minus one |
| cfg_v_sync_wid | input | VW | Vertical sync width minus one |
| cfg_v_disp | input | VW | Visible lines minus one |
| cfg_hs_inv | input | 1 | 1 makes horizontal sync active high |
| cfg_vs_inv | input | 1 | 1 makes vertical sync active high |
| pix_in | input | DW | Pixel word aligned with the counters |
| h_count | output | HW | Pixel counter |
| v_count | output | VW | Line counter |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de_out | output | 1 | Delayed display enable |
| left_zone | output | 1 | Delayed left-zone flag |
| pix_out | output | DW | Delayed pixel word, zero outside display |
| frame_irq | output | 1 | End-of-visible-frame pulse |
| vsync_irq | output | 1 | Vertical sync start pulse |
| param_error | output | 1 | Active settings are out of order |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is a shadow load and a configuration change. The bench writes new totals and both invert bits during the final pixel of a frame, so the load edge and the write coincide. A cycle-accurate model judges the result: the new line length and the new sync polarity must start at pixel 0 of the next frame, and no earlier.

The second pair is the two interrupts. The bench deliberately sets the vertical sync position equal to the vertical display setting. Both interrupt pulses must then fire in the same cycle, `param_error` must rise at the frame start, and scanning must continue undisturbed.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int DW  = 24,
  parameter int LAT = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_sync_pos,
  input  logic [HW-1:0] cfg_h_sync_wid,
  input  logic [HW-1:0] cfg_h_disp,
  input  logic [HW-1:0] cfg_h_bound,
  input  logic [VW-1:0] cfg_v_total,
  input  logic [VW-1:0] cfg_v_sync_pos,
  input  logic [VW-1:0] cfg_v_sync_wid,
  input  logic [VW-1:0] cfg_v_disp,
  input  logic          cfg_hs_inv,
  input  logic          cfg_vs_inv,
  input  logic [DW-1:0] pix_in,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          hsync,
  output logic          vsync,
  output logic          de_out,
  output logic          left_zone,
  output logic [DW-1:0] pix_out,
  output logic          frame_irq,
  output logic          vsync_irq,
  output logic          param_error
);
  localparam int PW = DW + 2;
  localparam logic [HW-1:0] HINC = 1;
  localparam logic [VW-1:0] VINC = 1;
  localparam logic [HW:0]   HONE = 1;
  localparam logic [VW:0]   VONE = 1;

  logic          start;
  logic [HW-1:0] htot, hsp, hsw, hdp, hdb;
  logic [VW-1:0] vtot, vsp, vsw, vdp;
  logic          hinv, vinv;

  logic line_end, frame_end, load;
  assign line_end  = h_count >= htot;
  assign frame_end = line_end && (v_count >= vtot);
  assign load      = start || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b1;
      htot <= '0; hsp <= '0; hsw <= '0; hdp <= '0; hdb <= '0;
      vtot <= '0; vsp <= '0; vsw <= '0; vdp <= '0;
      hinv <= 1'b0; vinv <= 1'b0;
    end else begin
      start <= 1'b0;
      if (load) begin
        htot <= cfg_h_total;    hsp <= cfg_h_sync_pos; hsw <= cfg_h_sync_wid;
        hdp  <= cfg_h_disp;     hdb <= cfg_h_bound;
        vtot <= cfg_v_total;    vsp <= cfg_v_sync_pos; vsw <= cfg_v_sync_wid;
        vdp  <= cfg_v_disp;
        hinv <= cfg_hs_inv;     vinv <= cfg_vs_inv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_count <= '0;
      v_count <= '0;
    end else if (!start) begin
      if (line_end) begin
        h_count <= '0;
        v_count <= frame_end ? '0 : v_count + VINC;
      end else begin
        h_count <= h_count + HINC;
      end
    end
  end

  logic [HW:0] hs_lo, hs_hi;
  logic [VW:0] vs_lo, vs_hi, vd_next;
  assign hs_lo   = {1'b0, hsp} + HONE;
  assign hs_hi   = {1'b0, hsp} + {1'b0, hsw} + HONE;
  assign vs_lo   = {1'b0, vsp} + VONE;
  assign vs_hi   = {1'b0, vsp} + {1'b0, vsw} + VONE;
  assign vd_next = {1'b0, vdp} + VONE;

  logic h_act, v_act, de_int, lz_int, legal;
  assign h_act = !start && ({1'b0, h_count} >= hs_lo) && ({1'b0, h_count} <= hs_hi);
  assign v_act = !start && ({1'b0, v_count} >= vs_lo) && ({1'b0, v_count} <= vs_hi);
  assign hsync = hinv ? h_act : !h_act;
  assign vsync = vinv ? v_act : !v_act;

  assign frame_irq = !start && (h_count == '0) && ({1'b0, v_count} == vd_next);
  assign vsync_irq = !start && (h_count == '0) && ({1'b0, v_count} == vs_lo);

  assign legal = (hdb <= hdp) && (hdp < hsp) && (hs_hi < {1'b0, htot})
              && (vdp < vsp) && (vs_hi < {1'b0, vtot});
  assign param_error = !start && !legal;

  assign de_int = !start && (h_count <= hdp) && (v_count <= vdp);
  assign lz_int = de_int && (h_count <= hdb);

  logic [PW-1:0] pipe [LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {de_int, lz_int, pix_in};
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign de_out    = pipe[LAT-1][DW+1];
  assign left_zone = pipe[LAT-1][DW];
  assign pix_out   = de_out ? pipe[LAT-1][DW-1:0] : '0;
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          frame_irq,
  input logic          vsync_irq,
  input logic          param_error
);
  localparam logic [HW-1:0] HSTEP = 1;

  a_r1_h_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count != '0) |-> (h_count == $past(h_count) + HSTEP));

  a_r2_v_moves_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    (v_count != $past(v_count)) |-> (h_count == '0));

  a_r5_frame_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  a_r6_vsync_irq_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_irq |-> (h_count == '0));

  a_r10_error_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (param_error != $past(param_error)) |-> (h_count == '0 && v_count == '0));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
  .frame_irq(frame_irq), .vsync_irq(vsync_irq), .param_error(param_error)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int HW = 12, VW = 11, DW = 24, LAT = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [HW-1:0] h_tot, h_sp, h_sw, h_dp, h_b;
  logic [VW-1:0] v_tot, v_sp, v_sw, v_dp;
  logic hs_inv, vs_inv;
  logic [DW-1:0] pix_in = '0;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  logic hsync, vsync, de_out, left_zone, frame_irq, vsync_irq, param_error;
  logic [DW-1:0] pix_out;

  raster_timing_gen #(.HW(HW), .VW(VW), .DW(DW), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(h_tot), .cfg_h_sync_pos(h_sp), .cfg_h_sync_wid(h_sw),
    .cfg_h_disp(h_dp), .cfg_h_bound(h_b),
    .cfg_v_total(v_tot), .cfg_v_sync_pos(v_sp), .cfg_v_sync_wid(v_sw),
    .cfg_v_disp(v_dp), .cfg_hs_inv(hs_inv), .cfg_vs_inv(vs_inv),
    .pix_in(pix_in), .h_count(h_count), .v_count(v_count),
    .hsync(hsync), .vsync(vsync), .de_out(de_out), .left_zone(left_zone),
    .pix_out(pix_out), .frame_irq(frame_irq), .vsync_irq(vsync_irq),
    .param_error(param_error));

  int ntests = 0, nfail = 0;
  int mh, mv;
  int ah_tot, ah_sp, ah_sw, ah_dp, ah_b, av_tot, av_sp, av_sw, av_dp;
  bit a_hinv, a_vinv;
  bit hde [LAT];
  bit hlz [LAT];
  logic [DW-1:0] hpx [LAT];
  bit both_seen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at h=%0d v=%0d: actual=%0d expected=%0d", req, mh, mv, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  task automatic load_active();
    ah_tot = h_tot; ah_sp = h_sp; ah_sw = h_sw; ah_dp = h_dp; ah_b = h_b;
    av_tot = v_tot; av_sp = v_sp; av_sw = v_sw; av_dp = v_dp;
    a_hinv = hs_inv; a_vinv = vs_inv;
  endtask

  function automatic bit legal_now();
    return (ah_b <= ah_dp) && (ah_dp < ah_sp) && (ah_sp + ah_sw + 1 < ah_tot)
        && (av_dp < av_sp) && (av_sp + av_sw + 1 < av_tot);
  endfunction

  task automatic set_cfg(input int ht, input int hsp, input int hsw, input int hdp, input int hb,
                         input int vt, input int vsp, input int vsw, input int vdp,
                         input bit hi, input bit vi);
    h_tot = HW'(ht); h_sp = HW'(hsp); h_sw = HW'(hsw); h_dp = HW'(hdp); h_b = HW'(hb);
    v_tot = VW'(vt); v_sp = VW'(vsp); v_sw = VW'(vsw); v_dp = VW'(vdp);
    hs_inv = hi; vs_inv = vi;
  endtask

  task automatic compare_all();
    bit ha, va, ed;
    logic [DW-1:0] ep;
    ha = (mh >= ah_sp + 1) && (mh <= ah_sp + ah_sw + 1);
    va = (mv >= av_sp + 1) && (mv <= av_sp + av_sw + 1);
    ed = hde[LAT-1];
    ep = ed ? hpx[LAT-1] : '0;
    chk(int'(h_count) == mh, "R1 R11 h_count", h_count, mh);
    chk(int'(v_count) == mv, "R2 R11 v_count", v_count, mv);
    chk(hsync == (a_hinv ? ha : !ha), "R3 hsync", hsync, a_hinv ? ha : !ha);
    chk(vsync == (a_vinv ? va : !va), "R4 vsync", vsync, a_vinv ? va : !va);
    chk(frame_irq == (mh == 0 && mv == av_dp + 1), "R5 frame_irq", frame_irq, mh == 0 && mv == av_dp + 1);
    chk(vsync_irq == (mh == 0 && mv == av_sp + 1), "R6 vsync_irq", vsync_irq, mh == 0 && mv == av_sp + 1);
    chk(de_out == ed, "R7 de_out", de_out, ed);
    chk(pix_out == ep, "R8 pix_out", pix_out, ep);
    chk(left_zone == hlz[LAT-1], "R9 left_zone", left_zone, hlz[LAT-1]);
    chk(param_error == !legal_now(), "R10 param_error", param_error, !legal_now());
    if (frame_irq && vsync_irq) both_seen = 1'b1;
  endtask

  task automatic step();
    bit d, l;
    logic [DW-1:0] p;
    d = (mh <= ah_dp) && (mv <= av_dp);
    l = d && (mh <= ah_b);
    p = pix_in;
    @(posedge clk);
    for (int i = LAT-1; i > 0; i--) begin
      hde[i] = hde[i-1]; hlz[i] = hlz[i-1]; hpx[i] = hpx[i-1];
    end
    hde[0] = d; hlz[0] = l; hpx[0] = p;
    if (mh >= ah_tot) begin
      mh = 0;
      if (mv >= av_tot) begin mv = 0; load_active(); end
      else mv++;
    end else mh++;
    #1;
    compare_all();
    pix_in = pix_in + 24'h010203;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    set_cfg(19, 9, 2, 7, 3, 9, 5, 1, 4, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(h_count == '0 && v_count == '0, "R12 counters in reset", {v_count, h_count}, 0);
    chk(hsync && vsync, "R12 syncs in reset", {hsync, vsync}, 3);
    chk(!de_out && !left_zone && pix_out == '0, "R12 data in reset", {de_out, left_zone, pix_out}, 0);
    chk(!frame_irq && !vsync_irq && !param_error, "R12 flags in reset",
        {frame_irq, vsync_irq, param_error}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    mh = 0; mv = 0; load_active();
    for (int i = 0; i < LAT; i++) begin hde[i] = 0; hlz[i] = 0; hpx[i] = '0; end
    #1;
    compare_all();
    pix_in = pix_in + 24'h010203;
  endtask

  task automatic t_frames();
    run(2 * 200 + 25);
  endtask

  task automatic t_shadow();
    while (!(mh == 6 && mv == 2)) step();
    set_cfg(15, 9, 2, 7, 3, 9, 5, 1, 4, 1, 1);
    run(30);
    while (!(mh == ah_tot && mv == av_tot)) step();
    run(2 * 160 + 10);
  endtask

  task automatic t_edge_write();
    while (!(mh == ah_tot && mv == av_tot)) step();
    set_cfg(21, 10, 3, 8, 8, 11, 6, 2, 5, 0, 1);
    run(2 * 22 * 12 + 5);
  endtask

  task automatic t_illegal();
    both_seen = 1'b0;
    while (!(mh == ah_tot && mv == av_tot)) step();
    set_cfg(19, 7, 2, 7, 9, 9, 4, 1, 4, 0, 0);
    run(2 * 200 + 5);
    chk(both_seen, "R5 R6 both pulses in one cycle", both_seen, 1);
  endtask

  task automatic t_recover();
    while (!(mh == ah_tot && mv == av_tot)) step();
    set_cfg(19, 9, 2, 7, 3, 9, 5, 1, 4, 0, 0);
    run(210);
    chk(!param_error, "R10 flag clears with legal settings", param_error, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_frames();
    t_shadow();
    t_edge_write();
    t_illegal();
    t_recover();
    summary();
    $finish;
  end
endmodule